// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit CPU address into one select line per memory region: on-chip RAM, the control-register block, EEPROM, ROM, or the external bus. It holds an 8-bit mapping register. The upper nibble of that register picks the 4-Kbyte page where RAM starts, and the lower nibble picks the page where the register block starts. Both regions always begin at the bottom of their page.

In normal operation, software may write the mapping register once, early after reset. The window is measured in E-clock enable pulses. Once a write has been accepted, or once the window has run out, the register no longer changes. A special-mode input lifts this restriction so that test and boot code can remap at any time.

Two configuration inputs can take ROM and EEPROM out of the on-chip map. Their address ranges then go to the external bus. A single-chip mode input keeps ROM present whatever the ROM enable says. The selects are combinational in the address. A change to the mapping register takes effect from the clock edge that stores it.

Top module: `memmap_decoder`

## Requirements
- R1: Reset leaves the mapping register at 0x01, so RAM decodes from 0x0000 and the register block from 0x1000. With `rd` high, `map_rdata` returns 0x01 at address 0x103D.
- R2: The register block is selected for the 64 bytes that start at page `map[3:0]` (address bits 15:12 equal `map[3:0]`, bits 11:0 below 64).
- R3: RAM is selected for the 512 bytes that start at page `map[7:4]` (address bits 15:12 equal `map[7:4]`, bits 11:0 below 512).
- R4: Exactly one of the five selects is high for every address. Where regions overlap, the priority from highest to lowest is register block, RAM, EEPROM, ROM, external.
- R5: In normal mode, a write is stored into the mapping register when all of the following hold:
  - `wr` and `e_en` are both high;
  - the address equals register-block base + 0x3D;
  - no write has been accepted yet;
  - fewer than 64 `e_en` pulses have occurred since reset (the 64th pulse may still carry a write).
- R6: In normal mode, every write after the first accepted write is ignored.
- R7: In normal mode, a write that arrives after 64 `e_en` pulses have occurred is ignored.
- R8: In special mode (`special_mode` high), every write to the mapping register address with `e_en` high is stored, however late it comes and however many writes came before it.
- R9: Addresses 0xD000–0xFFFF, unless claimed by a higher-priority region, select ROM when `rom_cfg_en` or `single_chip` is high, and otherwise select external.
- R10: Addresses 0xB600–0xB7FF, unless claimed by a higher-priority region, select EEPROM when `ee_cfg_en` is high, and otherwise fall to ROM or external.
- R11: `map_rdata` is 0 unless `rd` is high and the address equals the mapping register address. In that case it shows the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| e_en | input | 1 | E-clock enable: one pulse per bus cycle |
| addr | input | 16 | CPU address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rom_cfg_en | input | 1 | ROM enable configuration |
| ee_cfg_en | input | 1 | EEPROM enable configuration |
| single_chip | input | 1 | Single-chip mode; forces ROM on |
| special_mode | input | 1 | Test/boot mode; mapping register stays writable |
| map_rdata | output | 8 | Mapping register read data |
| sel_reg | output | 1 | Register block select |
| sel_ram | output | 1 | RAM select |
| sel_ee | output | 1 | EEPROM select |
| sel_rom | output | 1 | ROM select |
| sel_ext | output | 1 | External bus select |

## Verification
The bench goes after several window and priority corner cases:
- **Window edge.** A write on the 64th E pulse must be stored, and one on the 65th must be dropped. An off-by-one counter would flip one of these.
- **Write-once.** A second write must leave the first value in place. A design missing the lock would show the new value when the register is read back at its moved address.
- **Overlap.** Random mappings put RAM and the register block on the same page, or on the EEPROM or ROM pages. Broken priority would raise two selects at once, or the wrong one.
- **Mode handling.** Special mode must still accept writes well after the window has closed. Single-chip mode must keep ROM selected with its enable low.

// File: rtl/memmap_pkg.sv
`timescale 1ns/1ps
package memmap_pkg;

  typedef struct packed {
    logic regs;
    logic ram;
    logic ee;
    logic rom;
    logic ext;
  } region_sel_t;

  localparam int unsigned PAGE_W = 4;

endpackage

// File: rtl/memmap_page_win.sv
`timescale 1ns/1ps
module memmap_page_win #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned SIZE   = 512
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  localparam int unsigned OFF_W = ADDR_W - PAGE_W;

  logic [OFF_W:0] offset_x;
  logic           page_eq;

  always_comb begin
    offset_x = {1'b0, addr[OFF_W-1:0]};
    page_eq  = (addr[ADDR_W-1 -: PAGE_W] == page);
    hit      = page_eq && (offset_x < (OFF_W+1)'(SIZE));
  end
endmodule

// File: rtl/memmap_range_win.sv
`timescale 1ns/1ps
module memmap_range_win #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LO     = 32'hB600,
  parameter int unsigned HI     = 32'hB7FF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic              hit
);
  always_comb begin
    hit = en && (addr >= ADDR_W'(LO)) && (addr <= ADDR_W'(HI));
  end
endmodule

// File: rtl/memmap_map_reg.sv
`timescale 1ns/1ps
module memmap_map_reg #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WIN_CYCLES = 64,
  parameter logic [7:0]  RESET_VAL  = 8'h01,
  localparam int unsigned CNT_W     = $clog2(WIN_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_en,
  input  logic              wr_hit,
  input  logic              special_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] map_q,
  output logic              locked,
  output logic [CNT_W-1:0]  win_cnt
);
  logic [DATA_W-1:0] map_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              win_open;
  logic              writable;

  always_comb begin
    win_open = (cnt_q < CNT_W'(WIN_CYCLES));
    writable = special_mode || (!done_q && win_open);
    cnt_d    = cnt_q;
    map_d    = map_q;
    done_d   = done_q;
    if (e_en && win_open) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (e_en && wr_hit && writable) begin
      map_d  = wdata;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= DATA_W'(RESET_VAL);
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      map_q  <= map_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign locked  = !special_mode && (done_q || !win_open);
  assign win_cnt = cnt_q;
endmodule

// File: rtl/memmap_decoder.sv
`timescale 1ns/1ps
module memmap_decoder #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned REG_SIZE    = 64,
  parameter int unsigned RAM_SIZE    = 512,
  parameter int unsigned MAP_OFFSET  = 32'h3D,
  parameter logic [7:0]  MAP_RESET   = 8'h01,
  parameter int unsigned WIN_CYCLES  = 64,
  parameter int unsigned EE_LO       = 32'hB600,
  parameter int unsigned EE_HI       = 32'hB7FF,
  parameter int unsigned ROM_LO      = 32'hD000,
  parameter int unsigned ROM_HI      = 32'hFFFF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rom_cfg_en,
  input  logic              ee_cfg_en,
  input  logic              single_chip,
  input  logic              special_mode,
  output logic [DATA_W-1:0] map_rdata,
  output logic              sel_reg,
  output logic              sel_ram,
  output logic              sel_ee,
  output logic              sel_rom,
  output logic              sel_ext
);
  import memmap_pkg::*;

  localparam int unsigned REG_AW = $clog2(REG_SIZE);
  localparam int unsigned CNT_W  = $clog2(WIN_CYCLES + 1);

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic [SYNC_STAGES-1:0] rst_sync_d;
  logic                   rst_int_n;

  always_comb begin
    rst_sync_d = {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // mapping register
  logic [DATA_W-1:0] map_q;
  logic              locked;
  logic [CNT_W-1:0]  win_cnt;
  logic              map_hit;
  logic              wr_hit;

  // region windows
  logic reg_hit, ram_hit, ee_hit, rom_hit;
  logic rom_on;

  assign rom_on = rom_cfg_en || single_chip;

  memmap_page_win #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE(REG_SIZE)) u_reg_win (
    .addr(addr), .page(map_q[PAGE_W-1:0]), .hit(reg_hit));

  memmap_page_win #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE(RAM_SIZE)) u_ram_win (
    .addr(addr), .page(map_q[2*PAGE_W-1:PAGE_W]), .hit(ram_hit));

  memmap_range_win #(.ADDR_W(ADDR_W), .LO(EE_LO), .HI(EE_HI)) u_ee_win (
    .addr(addr), .en(ee_cfg_en), .hit(ee_hit));

  memmap_range_win #(.ADDR_W(ADDR_W), .LO(ROM_LO), .HI(ROM_HI)) u_rom_win (
    .addr(addr), .en(rom_on), .hit(rom_hit));

  always_comb begin
    map_hit = reg_hit && (addr[REG_AW-1:0] == REG_AW'(MAP_OFFSET));
    wr_hit  = wr && map_hit;
  end

  memmap_map_reg #(.DATA_W(DATA_W), .WIN_CYCLES(WIN_CYCLES), .RESET_VAL(MAP_RESET)) u_map_reg (
    .clk(clk), .rst_n(rst_int_n), .e_en(e_en), .wr_hit(wr_hit),
    .special_mode(special_mode), .wdata(wdata),
    .map_q(map_q), .locked(locked), .win_cnt(win_cnt));

  // fixed priority: register block, RAM, EEPROM, ROM, external
  region_sel_t sel;

  always_comb begin
    sel = '0;
    if      (reg_hit) sel.regs = 1'b1;
    else if (ram_hit) sel.ram  = 1'b1;
    else if (ee_hit)  sel.ee   = 1'b1;
    else if (rom_hit) sel.rom  = 1'b1;
    else              sel.ext  = 1'b1;
  end

  assign sel_reg = sel.regs;
  assign sel_ram = sel.ram;
  assign sel_ee  = sel.ee;
  assign sel_rom = sel.rom;
  assign sel_ext = sel.ext;

  always_comb begin
    map_rdata = (rd && map_hit) ? map_q : '0;
  end
endmodule

// File: rtl/memmap_decoder_chk.sv
`timescale 1ns/1ps
module memmap_decoder_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WIN_CYCLES = 64,
  parameter int unsigned EE_LO      = 32'hB600,
  parameter int unsigned EE_HI      = 32'hB7FF,
  parameter int unsigned ROM_LO     = 32'hD000,
  parameter int unsigned ROM_HI     = 32'hFFFF,
  localparam int unsigned CNT_W     = $clog2(WIN_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ee_cfg_en,
  input logic              rom_cfg_en,
  input logic              single_chip,
  input logic              special_mode,
  input logic              sel_reg,
  input logic              sel_ram,
  input logic              sel_ee,
  input logic              sel_rom,
  input logic              sel_ext,
  input logic [DATA_W-1:0] map_q,
  input logic              locked,
  input logic [CNT_W-1:0]  win_cnt
);
  logic in_rom, in_ee;
  assign in_rom = (addr >= ADDR_W'(ROM_LO)) && (addr <= ADDR_W'(ROM_HI));
  assign in_ee  = (addr >= ADDR_W'(EE_LO)) && (addr <= ADDR_W'(EE_HI));

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_reg, sel_ram, sel_ee, sel_rom, sel_ext}) == 1); // R4

  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !special_mode) |=> $stable(map_q)); // R6

  AST_WIN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CNT_W'(WIN_CYCLES)); // R7

  AST_EE_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cfg_en |-> !sel_ee); // R10

  AST_ROM_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rom && (rom_cfg_en || single_chip) && !sel_reg && !sel_ram) |-> sel_rom); // R9

  AST_EE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ee && ee_cfg_en && !sel_reg && !sel_ram) |-> sel_ee); // R10
endmodule

bind memmap_decoder memmap_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_CYCLES(WIN_CYCLES),
  .EE_LO(EE_LO), .EE_HI(EE_HI), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ee_cfg_en(ee_cfg_en),
  .rom_cfg_en(rom_cfg_en), .single_chip(single_chip), .special_mode(special_mode),
  .sel_reg(sel_reg), .sel_ram(sel_ram), .sel_ee(sel_ee), .sel_rom(sel_rom),
  .sel_ext(sel_ext), .map_q(map_q), .locked(locked), .win_cnt(win_cnt)
);

// File: tb/memmap_decoder_bench.sv
`timescale 1ns/1ps
module memmap_decoder_bench;
  logic        clk;
  logic        rst_n;
  logic        e_en;
  logic [15:0] addr;
  logic        rd, wr;
  logic [7:0]  wdata;
  logic        rom_cfg_en, ee_cfg_en, single_chip, special_mode;
  logic [7:0]  map_rdata;
  logic        sel_reg, sel_ram, sel_ee, sel_rom, sel_ext;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  logic [7:0] m_map;
  int         m_cnt;
  bit         m_done;

  memmap_decoder u_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .e_en(e_en), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rom_cfg_en(rom_cfg_en), .ee_cfg_en(ee_cfg_en),
    .single_chip(single_chip), .special_mode(special_mode),
    .map_rdata(map_rdata), .sel_reg(sel_reg), .sel_ram(sel_ram),
    .sel_ee(sel_ee), .sel_rom(sel_rom), .sel_ext(sel_ext));

  initial clk = 0;
  always #4 clk = ~clk;

  // {reg, ram, ee, rom, ext}
  function automatic logic [4:0] exp_sel(input logic [15:0] a, input logic [7:0] m,
                                         input bit rom, input bit ee, input bit sc);
    if (a[15:12] == m[3:0] && a[11:0] < 12'd64)        return 5'b10000;
    if (a[15:12] == m[7:4] && a[11:0] < 12'd512)       return 5'b01000;
    if (ee && a >= 16'hB600 && a <= 16'hB7FF)          return 5'b00100;
    if ((rom || sc) && a >= 16'hD000)                  return 5'b00010;
    return 5'b00001;
  endfunction

  function automatic logic [15:0] map_addr(input logic [7:0] m);
    return {m[3:0], 12'h03D};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, exp, addr);
    end
  endtask

  task automatic do_reset(input bit rom, input bit ee, input bit sc, input bit sp);
    @(negedge clk);
    rst_n = 0; e_en = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    rom_cfg_en = rom; ee_cfg_en = ee; single_chip = sc; special_mode = sp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_map = 8'h01; m_cnt = 0; m_done = 0;
  endtask

  task automatic bus(input string tag, input logic [15:0] a, input bit r, input bit w,
                     input logic [7:0] d, input bit e);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d; e_en = e;
    #1;
    check({tag, " sel"}, {11'd0, sel_reg, sel_ram, sel_ee, sel_rom, sel_ext},
          {11'd0, exp_sel(a, m_map, rom_cfg_en, ee_cfg_en, single_chip)});
    check({tag, " rdata"}, {8'd0, map_rdata},
          {8'd0, (r && a == map_addr(m_map)) ? m_map : 8'h00});
    @(posedge clk);
    if (e) begin
      if (w && a == map_addr(m_map) && (special_mode || (!m_done && m_cnt < 64))) begin
        m_map = d; m_done = 1;
      end
      if (m_cnt < 64) m_cnt++;
    end
  endtask

  task automatic idle_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr = 16'h8000; rd = 0; wr = 0; e_en = 1;
      @(posedge clk);
      if (m_cnt < 64) m_cnt++;
    end
    @(negedge clk);
    e_en = 0;
  endtask

  initial begin
    automatic int seed = $urandom(32'd2024);
    seed = 0;
    rst_n = 0; e_en = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    rom_cfg_en = 1; ee_cfg_en = 1; single_chip = 0; special_mode = 0;

    // R1: reset mapping
    do_reset(1, 1, 0, 0);
    bus("R1 default read", 16'h103D, 1, 0, 8'h00, 0);
    bus("R1 ram at 0000", 16'h0000, 0, 0, 8'h00, 0);
    bus("R1 reg at 1000", 16'h1000, 0, 0, 8'h00, 0);
    bus("R11 no rd", 16'h103D, 0, 0, 8'h00, 0);
    bus("R11 other addr", 16'h103C, 1, 0, 8'h00, 0);
    bus("R2 reg edge", 16'h103F, 0, 0, 8'h00, 0);
    bus("R2 past reg", 16'h1040, 0, 0, 8'h00, 0);
    bus("R3 ram edge", 16'h01FF, 0, 0, 8'h00, 0);
    bus("R3 past ram", 16'h0200, 0, 0, 8'h00, 0);

    // R5 accept, R6 write-once
    bus("R5 write", 16'h103D, 0, 1, 8'h23, 1);
    bus("R5 moved read", 16'h303D, 1, 0, 8'h00, 0);
    bus("R6 second write", 16'h303D, 0, 1, 8'h45, 1);
    bus("R6 readback", 16'h303D, 1, 0, 8'h00, 0);
    bus("R3 ram moved", 16'h2010, 0, 0, 8'h00, 0);
    bus("R5 no e_en", 16'h303D, 1, 0, 8'h00, 0);

    // R5 write without e_en is ignored
    do_reset(1, 1, 0, 0);
    bus("R5 wr no e", 16'h103D, 0, 1, 8'h66, 0);
    bus("R5 after no-e", 16'h103D, 1, 0, 8'h00, 0);

    // R7 window closed after 64 pulses
    do_reset(1, 1, 0, 0);
    idle_pulses(64);
    bus("R7 late write", 16'h103D, 0, 1, 8'h77, 1);
    bus("R7 readback", 16'h103D, 1, 0, 8'h00, 0);

    // R5 last slot: 63 pulses then the 64th carries the write
    do_reset(1, 1, 0, 0);
    idle_pulses(63);
    bus("R5 last slot", 16'h103D, 0, 1, 8'h56, 1);
    bus("R5 last readback", 16'h603D, 1, 0, 8'h00, 0);

    // R8 special mode
    do_reset(1, 1, 0, 1);
    idle_pulses(100);
    bus("R8 late write", 16'h103D, 0, 1, 8'h9A, 1);
    bus("R8 second write", 16'hA03D, 0, 1, 8'hB2, 1);
    bus("R8 readback", 16'h203D, 1, 0, 8'h00, 0);

    // R9 / R10 configuration
    do_reset(0, 0, 0, 0);
    bus("R9 rom off", 16'hE000, 0, 0, 8'h00, 0);
    bus("R10 ee off", 16'hB700, 0, 0, 8'h00, 0);
    do_reset(0, 0, 1, 0);
    bus("R9 single chip", 16'hFFFF, 0, 0, 8'h00, 0);
    bus("R9 below rom", 16'hCFFF, 0, 0, 8'h00, 0);
    do_reset(1, 1, 0, 0);
    bus("R10 ee lo", 16'hB600, 0, 0, 8'h00, 0);
    bus("R10 ee hi", 16'hB7FF, 0, 0, 8'h00, 0);
    bus("R10 past ee", 16'hB800, 0, 0, 8'h00, 0);

    // R4 overlap: RAM and registers on ROM page D, EEPROM page
    do_reset(1, 1, 0, 0);
    bus("R4 map DD", 16'h103D, 0, 1, 8'hDD, 1);
    bus("R4 reg over ram", 16'hD000, 0, 0, 8'h00, 0);
    bus("R4 ram over rom", 16'hD100, 0, 0, 8'h00, 0);
    bus("R4 rom after ram", 16'hD200, 0, 0, 8'h00, 0);

    // R4 random mappings and addresses
    for (int k = 0; k < 24; k++) begin
      automatic logic [7:0] mv = 8'($urandom);
      do_reset(1'($urandom), 1'($urandom), 1'($urandom), 0);
      bus("R5 rand map", 16'h103D, 0, 1, mv, 1);
      for (int j = 0; j < 120; j++) begin
        automatic logic [15:0] a;
        case ($urandom % 4)
          0: a = {m_map[3:0], 12'($urandom % 80)};
          1: a = {m_map[7:4], 12'($urandom % 600)};
          2: a = 16'hB5F0 + 16'($urandom % 560);
          default: a = 16'($urandom);
        endcase
        rom_cfg_en  = 1'($urandom);
        ee_cfg_en   = 1'($urandom);
        single_chip = 1'($urandom);
        bus("R4 rand", a, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule